// File: doc/BRIEF.md
# Carry-Save Multiplier Step Unit

This block performs one step of a serial shift-and-add multiplier whose running sum is held in carry-save form. Operands circulate through an external loop. Each step takes three words from three ready/valid input channels and returns three words on three ready/valid output channels. The steps alternate between two operations. A partial-product step gates the multiplicand by the current multiplier bit and shifts the multiplier. A compress step reduces three words to a carry word and a shifted sum word, and moves the sum's low bit into an internal bit buffer as one finished product bit.

A step counter selects the operation by its parity. After the final step of an operand, the unit runs a fixed number of internal compress iterations, one per clock, to drain the remaining carry-save state into the bit buffer. Whenever enough bits are waiting, the buffer offers them as one word on a fourth output channel. Sign handling and the loop plumbing belong to the surrounding logic.

Top module: `csa_mul_step`

## Requirements
- R1: A step fires in a cycle only when all three inputs are valid, each of the X, Y and Z output channels can accept (its valid is low or its ready is high), the bit buffer holds fewer than 74 bits, and no flush is running. `a_ready`, `b_ready` and `c_ready` are high exactly in such a cycle, and all three words are consumed together.
- R2: The step counter resets to 74. It drops by one on each fired step. The step taken at count 1 reloads it to 74.
- R3: A step at an even count loads X with A, loads Y with B logically shifted right by one with a zero MSB, and loads Z with A when bit 0 of B is 1 and with zero otherwise.
- R4: A step at an odd count loads X with the bitwise majority of A, B and C, loads Y with (A xor B xor C) shifted right by one with a zero MSB, and loads Z with zero.
- R5: A step at an odd count appends bit 0 of A xor B xor C to the bit buffer.
- R6: The step at count 1 starts a flush of 37 internal compress iterations, starting from that step's X, Y and Z results. Each iteration appends its sum bit 0 to the buffer, and each iteration feeds its majority and shifted sum, with zero as the third word, to the next. The flush runs one iteration per clock, holds off while the buffer is full, and blocks new steps until it has finished.
- R7: The bit buffer holds at most 74 bits. `bits_valid` is high while it holds at least 37 bits. A handshake on the bits channel removes the 37 oldest bits, with the oldest at bit 0 of `bits_data`. A pop and a push in the same cycle both take effect.
- R8: Each of the X, Y and Z channels keeps its valid high and its data stable until the channel's ready is sampled high. Without a new step, its valid then drops.
- R9: A synchronous reset empties the bit buffer, cancels any flush, reloads the counter to 74 and clears the X, Y and Z valids.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_valid | input | 1 | Input A word valid |
| a_ready | output | 1 | Input A word consumed |
| a_data | input | 37 | Input A word (multiplicand or first sum word) |
| b_valid | input | 1 | Input B word valid |
| b_ready | output | 1 | Input B word consumed |
| b_data | input | 37 | Input B word (multiplier or second sum word) |
| c_valid | input | 1 | Input C word valid |
| c_ready | output | 1 | Input C word consumed |
| c_data | input | 37 | Input C word (partial product) |
| x_valid | output | 1 | Output X valid |
| x_ready | input | 1 | Output X accepted |
| x_data | output | 37 | Output X word |
| y_valid | output | 1 | Output Y valid |
| y_ready | input | 1 | Output Y accepted |
| y_data | output | 37 | Output Y word |
| z_valid | output | 1 | Output Z valid |
| z_ready | input | 1 | Output Z accepted |
| z_data | output | 37 | Output Z word |
| bits_valid | output | 1 | A chunk of product bits is available |
| bits_ready | input | 1 | Chunk accepted |
| bits_data | output | 37 | Oldest 37 product bits, oldest at bit 0 |

## Verification
The bound checker watches every cycle for the local rules. Inputs are consumed only when all three are valid and the buffer has room. The counter steps down by one or reloads after count 1. An even step passes A to X, and an odd step clears Z. No step fires during a flush. The buffer fill never exceeds its depth, and a stalled output holds its word. What only the bench's scenarios can show is the arithmetic across many steps: the majority and shifted-XOR words, the partial-product gating, the exact bit order of each emitted chunk, the length of the flush and its stall against a full buffer, and the effect of a reset in mid-operand. For this the bench uses a queue-based model compared on every clock under steady, random and back-pressured traffic.

// File: rtl/csm_pkg.sv
package csm_pkg;
   // Operation chosen for a step by the counter parity
   typedef enum logic {
      OP_PARTIAL  = 1'b0,
      OP_COMPRESS = 1'b1
   } csm_op_e;
endpackage

// File: rtl/csm_partial.sv
// Partial-product stage: X = A, Y = B >> 1, Z = B[0] ? A : 0
module csm_partial #(
   parameter int W = 37
) (
   input  logic [W-1:0] mcand,
   input  logic [W-1:0] mplier,
   output logic [W-1:0] pass_o,
   output logic [W-1:0] shift_o,
   output logic [W-1:0] gated_o
);
   assign pass_o  = mcand;
   assign shift_o = {1'b0, mplier[W-1:1]};
   for (genvar i = 0; i < W; i++) begin : g_gate
      assign gated_o[i] = mcand[i] & mplier[0];
   end
endmodule

// File: rtl/csm_compress.sv
// 3:2 compressor: carry word, sum word shifted right by one, sum LSB
module csm_compress #(
   parameter int W = 37
) (
   input  logic [W-1:0] p,
   input  logic [W-1:0] q,
   input  logic [W-1:0] r,
   output logic [W-1:0] carry_o,
   output logic [W-1:0] sum_sh_o,
   output logic         sum_lsb_o
);
   logic [W-1:0] sum;
   assign sum       = p ^ q ^ r;
   assign carry_o   = (p & q) | (q & r) | (p & r);
   assign sum_sh_o  = {1'b0, sum[W-1:1]};
   assign sum_lsb_o = sum[0];
endmodule

// File: rtl/csm_ctrl.sv
// Step counter and flush sequencer
module csm_ctrl #(
   parameter int STEPS       = 74,
   parameter int FLUSH_ITERS = 37,
   localparam int CW = $clog2(STEPS + 1),
   localparam int LW = $clog2(FLUSH_ITERS + 1)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 fire,
   input  logic                 flush_adv,
   output csm_pkg::csm_op_e     op,
   output logic                 last_step,
   output logic                 flushing,
   output logic [CW-1:0]        cnt
);
   logic [CW-1:0] cnt_q;
   logic [LW-1:0] left_q;

   assign cnt       = cnt_q;
   assign op        = cnt_q[0] ? csm_pkg::OP_COMPRESS : csm_pkg::OP_PARTIAL;
   assign last_step = (cnt_q == CW'(1));
   assign flushing  = (left_q != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= CW'(STEPS);
         left_q <= '0;
      end else begin
         if (fire) begin
            cnt_q <= last_step ? CW'(STEPS) : cnt_q - CW'(1);
         end
         if (fire && last_step) begin
            left_q <= LW'(FLUSH_ITERS);
         end else if (flush_adv) begin
            left_q <= left_q - LW'(1);
         end
      end
   end
endmodule

// File: rtl/csm_bitbuf.sv
// Bit FIFO: single-bit push, CHUNK-bit pop, oldest bit at index 0
module csm_bitbuf #(
   parameter int DEPTH = 74,
   parameter int CHUNK = 37,
   localparam int FW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic             push_bit,
   input  logic             pop,
   output logic             room,
   output logic             out_valid,
   output logic [CHUNK-1:0] out_data,
   output logic [FW-1:0]    fill
);
   logic [DEPTH-1:0] mem_q, mem_d;
   logic [FW-1:0]    fill_q, fill_d;

   assign fill      = fill_q;
   assign room      = (fill_q < FW'(DEPTH));
   assign out_valid = (fill_q >= FW'(CHUNK));
   assign out_data  = mem_q[CHUNK-1:0];

   always_comb begin
      mem_d  = mem_q;
      fill_d = fill_q;
      if (pop) begin
         mem_d  = mem_q >> CHUNK;
         fill_d = fill_q - FW'(CHUNK);
      end
      if (push) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (FW'(i) == fill_d) mem_d[i] = push_bit;
         end
         fill_d = fill_d + FW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mem_q  <= '0;
         fill_q <= '0;
      end else begin
         mem_q  <= mem_d;
         fill_q <= fill_d;
      end
   end
endmodule

// File: rtl/csa_mul_step.sv
module csa_mul_step #(
   parameter int W           = 37,
   parameter int STEPS       = 74,
   parameter int FLUSH_ITERS = 37,
   parameter int DEPTH       = 74,
   parameter int CHUNK       = 37
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             a_valid,
   output logic             a_ready,
   input  logic [W-1:0]     a_data,
   input  logic             b_valid,
   output logic             b_ready,
   input  logic [W-1:0]     b_data,
   input  logic             c_valid,
   output logic             c_ready,
   input  logic [W-1:0]     c_data,
   output logic             x_valid,
   input  logic             x_ready,
   output logic [W-1:0]     x_data,
   output logic             y_valid,
   input  logic             y_ready,
   output logic [W-1:0]     y_data,
   output logic             z_valid,
   input  logic             z_ready,
   output logic [W-1:0]     z_data,
   output logic             bits_valid,
   input  logic             bits_ready,
   output logic [CHUNK-1:0] bits_data
);
   localparam int CW = $clog2(STEPS + 1);
   localparam int FW = $clog2(DEPTH + 1);

   if (STEPS < 2 || (STEPS % 2) != 0) begin : g_bad_steps
      $error("STEPS must be even and at least 2");
   end
   if (CHUNK < 1 || CHUNK > DEPTH) begin : g_bad_chunk
      $error("CHUNK must lie in 1..DEPTH");
   end
   if (FLUSH_ITERS < 1 || W < 2) begin : g_bad_misc
      $error("FLUSH_ITERS must be positive and W at least 2");
   end

   csm_pkg::csm_op_e op;
   logic          last_step, flushing, flush_adv, fire, room;
   logic [CW-1:0] step_cnt;
   logic [FW-1:0] buf_fill;

   logic [W-1:0] pp_x, pp_y, pp_z;
   logic [W-1:0] st_carry, st_sum;
   logic         st_lsb;
   logic [W-1:0] fl_a_q, fl_b_q, fl_carry, fl_sum;
   logic         fl_lsb;
   logic         push, push_bit;

   logic         can_x, can_y, can_z;
   logic [W-1:0] x_q, y_q, z_q;
   logic         xv_q, yv_q, zv_q;

   assign can_x = !xv_q || x_ready;
   assign can_y = !yv_q || y_ready;
   assign can_z = !zv_q || z_ready;
   assign fire  = a_valid && b_valid && c_valid && can_x && can_y && can_z
                  && room && !flushing;
   assign a_ready = fire;
   assign b_ready = fire;
   assign c_ready = fire;
   assign flush_adv = flushing && room;

   csm_ctrl #(.STEPS(STEPS), .FLUSH_ITERS(FLUSH_ITERS)) u_ctrl (
      .clk(clk), .rst(rst), .fire(fire), .flush_adv(flush_adv),
      .op(op), .last_step(last_step), .flushing(flushing), .cnt(step_cnt)
   );

   csm_partial #(.W(W)) u_pp (
      .mcand(a_data), .mplier(b_data),
      .pass_o(pp_x), .shift_o(pp_y), .gated_o(pp_z)
   );

   csm_compress #(.W(W)) u_step_cmp (
      .p(a_data), .q(b_data), .r(c_data),
      .carry_o(st_carry), .sum_sh_o(st_sum), .sum_lsb_o(st_lsb)
   );

   csm_compress #(.W(W)) u_flush_cmp (
      .p(fl_a_q), .q(fl_b_q), .r('0),
      .carry_o(fl_carry), .sum_sh_o(fl_sum), .sum_lsb_o(fl_lsb)
   );

   assign push     = (fire && op == csm_pkg::OP_COMPRESS) || flush_adv;
   assign push_bit = flushing ? fl_lsb : st_lsb;

   csm_bitbuf #(.DEPTH(DEPTH), .CHUNK(CHUNK)) u_buf (
      .clk(clk), .rst(rst), .push(push), .push_bit(push_bit),
      .pop(bits_valid && bits_ready), .room(room),
      .out_valid(bits_valid), .out_data(bits_data), .fill(buf_fill)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         xv_q <= 1'b0;
         yv_q <= 1'b0;
         zv_q <= 1'b0;
      end else if (fire) begin
         xv_q <= 1'b1;
         yv_q <= 1'b1;
         zv_q <= 1'b1;
      end else begin
         if (x_ready) xv_q <= 1'b0;
         if (y_ready) yv_q <= 1'b0;
         if (z_ready) zv_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (fire) begin
         if (op == csm_pkg::OP_PARTIAL) begin
            x_q <= pp_x;
            y_q <= pp_y;
            z_q <= pp_z;
         end else begin
            x_q <= st_carry;
            y_q <= st_sum;
            z_q <= '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fire && last_step) begin
         fl_a_q <= st_carry;
         fl_b_q <= st_sum;
      end else if (flush_adv) begin
         fl_a_q <= fl_carry;
         fl_b_q <= fl_sum;
      end
   end

   assign x_valid = xv_q;
   assign y_valid = yv_q;
   assign z_valid = zv_q;
   assign x_data  = x_q;
   assign y_data  = y_q;
   assign z_data  = z_q;
endmodule

// File: rtl/csm_step_chk.sv
module csm_step_chk #(
   parameter int W     = 37,
   parameter int STEPS = 74,
   parameter int DEPTH = 74,
   localparam int CW = $clog2(STEPS + 1),
   localparam int FW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst,
   input logic          a_valid,
   input logic          b_valid,
   input logic          c_valid,
   input logic          a_ready,
   input logic [W-1:0]  a_data,
   input logic          x_valid,
   input logic          x_ready,
   input logic [W-1:0]  x_data,
   input logic [W-1:0]  z_data,
   input logic [CW-1:0] step_cnt,
   input logic [FW-1:0] buf_fill,
   input logic          flushing
);
   AST_FIRE_NEEDS_INPUTS: assert property (@(posedge clk) disable iff (rst)
      a_ready |-> (a_valid && b_valid && c_valid && buf_fill < FW'(DEPTH))); // R1
   AST_CNT_DECREMENT: assert property (@(posedge clk) disable iff (rst)
      (a_ready && step_cnt != CW'(1)) |=> step_cnt == $past(step_cnt) - CW'(1)); // R2
   AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (rst)
      (a_ready && step_cnt == CW'(1)) |=> step_cnt == CW'(STEPS)); // R2
   AST_EVEN_PASS_A: assert property (@(posedge clk) disable iff (rst)
      (a_ready && !step_cnt[0]) |=> x_data == $past(a_data)); // R3
   AST_ODD_Z_ZERO: assert property (@(posedge clk) disable iff (rst)
      (a_ready && step_cnt[0]) |=> z_data == '0); // R4
   AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      flushing |-> !a_ready); // R6
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      buf_fill <= FW'(DEPTH)); // R7
   AST_X_HOLD: assert property (@(posedge clk) disable iff (rst)
      (x_valid && !x_ready) |=> (x_valid && $stable(x_data))); // R8
endmodule

bind csa_mul_step csm_step_chk #(.W(W), .STEPS(STEPS), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst(rst),
   .a_valid(a_valid), .b_valid(b_valid), .c_valid(c_valid),
   .a_ready(a_ready), .a_data(a_data),
   .x_valid(x_valid), .x_ready(x_ready), .x_data(x_data),
   .z_data(z_data), .step_cnt(step_cnt), .buf_fill(buf_fill),
   .flushing(flushing)
);

// File: tb/test_csa_mul_step.sv
`timescale 1ns/1ps
module test_csa_mul_step;
   localparam int W = 37;
   localparam int STEPS = 74;
   localparam int FLUSH = 37;
   localparam int DEPTH = 74;
   localparam int CHUNK = 37;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic a_valid = 0, b_valid = 0, c_valid = 0;
   logic a_ready, b_ready, c_ready;
   logic [W-1:0] a_data = '0, b_data = '0, c_data = '0;
   logic x_valid, y_valid, z_valid;
   logic x_ready = 0, y_ready = 0, z_ready = 0;
   logic [W-1:0] x_data, y_data, z_data;
   logic bits_valid;
   logic bits_ready = 0;
   logic [CHUNK-1:0] bits_data;

   always #4 clk = ~clk;

   csa_mul_step i_csa_mul_step (
      .clk(clk), .rst(rst),
      .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
      .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
      .c_valid(c_valid), .c_ready(c_ready), .c_data(c_data),
      .x_valid(x_valid), .x_ready(x_ready), .x_data(x_data),
      .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data),
      .z_valid(z_valid), .z_ready(z_ready), .z_data(z_data),
      .bits_valid(bits_valid), .bits_ready(bits_ready), .bits_data(bits_data)
   );

   // Reference model state
   int unsigned errors = 0, checks = 0;
   int m_cnt = STEPS;
   int m_left = 0;
   bit m_xv = 0, m_yv = 0, m_zv = 0;
   logic [W-1:0] m_x = '0, m_y = '0, m_z = '0, m_s1 = '0, m_s2 = '0;
   bit q[$];
   bit last_fire = 0;
   bit last_odd = 0;
   int p_in = 100, p_out = 100, p_bit = 100, dmode = 0;

   function automatic bit exp_fire();
      return a_valid && b_valid && c_valid && (!m_xv || x_ready) &&
             (!m_yv || y_ready) && (!m_zv || z_ready) &&
             (q.size() < DEPTH) && (m_left == 0);
   endfunction

   function automatic logic [W-1:0] maj(input logic [W-1:0] p, r, s);
      logic [W-1:0] o;
      for (int i = 0; i < W; i++) o[i] = (int'(p[i]) + int'(r[i]) + int'(s[i])) >= 2;
      return o;
   endfunction

   function automatic logic [W-1:0] shr1(input logic [W-1:0] v);
      logic [W-1:0] o;
      o = '0;
      for (int i = 0; i < W - 1; i++) o[i] = v[i+1];
      return o;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_cnt = STEPS; m_left = 0;
         m_xv = 0; m_yv = 0; m_zv = 0;
         q.delete();
         last_fire = 0;
      end else begin
         bit room, fire, fl, pop;
         logic [W-1:0] sx;
         room = q.size() < DEPTH;
         fire = exp_fire();
         fl   = (m_left > 0) && room;
         pop  = (q.size() >= CHUNK) && bits_ready;
         if (fire) begin
            m_xv = 1; m_yv = 1; m_zv = 1;
            last_odd = (m_cnt % 2) == 1;
            if (!last_odd) begin
               m_x = a_data;
               m_y = shr1(b_data);
               m_z = b_data[0] ? a_data : '0;
            end else begin
               m_x = maj(a_data, b_data, c_data);
               m_y = shr1(a_data ^ b_data ^ c_data);
               m_z = '0;
            end
         end else begin
            if (x_ready) m_xv = 0;
            if (y_ready) m_yv = 0;
            if (z_ready) m_zv = 0;
         end
         if (pop) for (int i = 0; i < CHUNK; i++) void'(q.pop_front());
         if (fire && last_odd) begin
            sx = a_data ^ b_data ^ c_data;
            q.push_back(sx[0]);
         end
         if (fl) begin
            sx = m_s1 ^ m_s2;
            q.push_back(sx[0]);
            m_s1 = maj(m_s1, m_s2, '0);
            m_s2 = shr1(sx);
            m_left--;
         end
         if (fire) begin
            if (m_cnt == 1) begin
               m_s1 = m_x; m_s2 = m_y; m_left = FLUSH; m_cnt = STEPS;
            end else begin
               m_cnt--;
            end
         end
         last_fire = fire;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [W-1:0] rnd_word();
      logic [63:0] t;
      t = {$urandom, $urandom};
      case (dmode)
         1: return '1;
         2: return t[W-1:0] | W'(1);
         default: return t[W-1:0];
      endcase
   endfunction

   function automatic bit coin(input int pct);
      return ($urandom % 100) < pct;
   endfunction

   task automatic compare_all();
      logic [CHUNK-1:0] eb;
      bit ef;
      string dtag;
      ef = exp_fire();
      dtag = last_odd ? "R4" : "R3";
      chk(a_ready == ef && b_ready == ef && c_ready == ef, "R1", "input ready", 64'(a_ready), 64'(ef));
      chk(x_valid == m_xv, "R8", "x_valid", 64'(x_valid), 64'(m_xv));
      chk(y_valid == m_yv, "R8", "y_valid", 64'(y_valid), 64'(m_yv));
      chk(z_valid == m_zv, "R8", "z_valid", 64'(z_valid), 64'(m_zv));
      if (m_xv) chk(x_data == m_x, dtag, "x_data (R2 phase)", 64'(x_data), 64'(m_x));
      if (m_yv) chk(y_data == m_y, dtag, "y_data (R2 phase)", 64'(y_data), 64'(m_y));
      if (m_zv) chk(z_data == m_z, dtag, "z_data (R2 phase)", 64'(z_data), 64'(m_z));
      chk(bits_valid == (q.size() >= CHUNK), "R7", "bits_valid",
          64'(bits_valid), 64'(q.size() >= CHUNK));
      if (q.size() >= CHUNK) begin
         for (int i = 0; i < CHUNK; i++) eb[i] = q[i];
         chk(bits_data == eb, "R5 R6 R7", "bits_data", 64'(bits_data), 64'(eb));
      end
   endtask

   task automatic run(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (last_fire || !a_valid) begin a_valid = coin(p_in); a_data = rnd_word(); end
         if (last_fire || !b_valid) begin b_valid = coin(p_in); b_data = rnd_word(); end
         if (last_fire || !c_valid) begin c_valid = coin(p_in); c_data = rnd_word(); end
         x_ready = coin(p_out);
         y_ready = coin(p_out);
         z_ready = coin(p_out);
         bits_ready = coin(p_bit);
         #1;
         compare_all();
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      #1;
      // R9: state after reset
      chk(!x_valid && !y_valid && !z_valid, "R9", "valids after reset",
          64'({x_valid, y_valid, z_valid}), 64'(0));
      chk(!bits_valid, "R9", "bits_valid after reset", 64'(bits_valid), 64'(0));
      // Full throughput: steps, flushes, chunk pops (R1..R7)
      p_in = 100; p_out = 100; p_bit = 100; run(400);
      // All-ones and odd-multiplier data
      dmode = 1; run(250);
      dmode = 2; run(250);
      dmode = 0;
      // Random back-pressure on every channel (R1, R8)
      p_in = 60; p_out = 70; p_bit = 50; run(1500);
      // Bits channel blocked: buffer fills, steps and flush stall (R1, R6)
      p_in = 100; p_out = 100; p_bit = 0; run(300);
      chk(bits_valid && !a_ready, "R6", "stall with full buffer",
          64'({bits_valid, a_ready}), 64'(2));
      // Reset in mid-operand with a full buffer (R9)
      @(negedge clk); rst = 1;
      @(negedge clk); @(negedge clk); rst = 0;
      #1;
      chk(!bits_valid, "R9", "buffer emptied by reset", 64'(bits_valid), 64'(0));
      chk(!x_valid, "R9", "x_valid cleared by reset", 64'(x_valid), 64'(0));
      p_bit = 100; run(300);
      p_in = 40; p_out = 40; p_bit = 90; run(1000);
      p_in = 100; p_out = 100; p_bit = 30; run(600);
      finish_run();
   end
endmodule